// File: doc/BRIEF.md
# Multiplexed-Bus Register and User-RAM Slave

This block is the host-facing slave of a small byte-wide register space reached over a shared address/data bus. On this bus the host first puts an address on the lines with the address-latch strobe (ALE) high. It then uses the same lines for data, under an active-low chip select and separate active-low read and write strobes. The block holds a 128-byte array. The low fourteen bytes serve as control registers and the upper 114 bytes as user RAM.

All bus inputs are taken as synchronous to the block clock, and the block finds their edges by comparing each input with its value at the previous clock edge. The pad is given as separate inbound data, outbound data and an output enable. A dedicated active-low wipe input, gated by a software-writable enable bit, starts a sweep that zeroes the user RAM one byte per clock. The control registers are left as they are.

Top module: `mbus_reg_if`

## Requirements
- R1: The address register takes `ad_in[6:0]` at the clock edge where `ale` is seen low after having been high at the previous edge. `ad_in[7]` is ignored as an address bit.
- R2: An ALE cycle with `cs_n` high still updates the address register, but the strobes that follow with `cs_n` high move no data.
- R3: A write is committed at the edge where `wr_n` is first seen high after being low, and only if `cs_n` was low at the preceding edge. The value written is the last `ad_in` sampled while `cs_n` and `wr_n` were both low. If `cs_n` rises before `wr_n`, nothing is written.
- R4: `ad_oe` is high exactly when `cs_n` and `rd_n` are both low, and `ad_out` then shows the byte at the latched address in the same cycle.
- R5: When the wipe enable (bit 0 of byte 0x0A) is 1, a falling edge of `clr_n` starts a sweep that writes zero to addresses 0x0E to 0x7F in ascending order, one per clock. `clr_busy` is high for exactly 114 cycles, starting the cycle after the edge that sees `clr_n` low. `clr_done` is a one-cycle pulse in the first cycle after `clr_busy` falls.
- R6: With the wipe enable at 0, driving `clr_n` low has no effect: `clr_busy` stays low and user RAM keeps its contents.
- R7: Bytes 0x00 to 0x0D, including the wipe enable, keep their values through a sweep.
- R8: Host writes that commit while `clr_busy` is high are dropped. A sweep runs to the end even when `clr_n` returns high after one cycle.
- R9: After synchronous reset all 128 bytes read as zero, and `ad_oe`, `clr_busy` and `clr_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch strobe, address taken on its fall |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_in | input | 8 | Inbound side of the shared address/data lines |
| ad_out | output | 8 | Outbound read data |
| ad_oe | output | 1 | Drive enable for the shared lines |
| clr_n | input | 1 | User-RAM wipe request, active low |
| clr_busy | output | 1 | Sweep in progress |
| clr_done | output | 1 | One-cycle pulse when a sweep ends |

## Verification
An address is held from the edge where ALE is first seen low. A write lands in the array at the edge where the write strobe is first seen high, so a read one cycle later already returns it. The bench drives every input 2 ns after a rising edge and samples at the falling edge, so each value it checks is the one settled after the edge that was counted. Read data and `ad_oe` are combinational from the latched address, so they are compared at the falling edge of the cycle in which the bench lowers the read strobe. For a wipe, the bench counts `clr_busy` and `clr_done` over a fixed window of falling edges, expecting 114 and 1. It reads the array back only after the sweep has ended.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int unsigned DATA_W      = 8;
    localparam int unsigned ADDR_W      = 7;
    localparam int unsigned DEPTH       = 1 << ADDR_W;
    localparam int unsigned USER_BASE   = 14;
    localparam int unsigned USER_BYTES  = DEPTH - USER_BASE;
    localparam int unsigned CLR_EN_ADDR = 10;
    localparam int unsigned CLR_EN_BIT  = 0;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_state_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t data;
    } wr_port_t;

    function automatic logic is_last(input addr_t a);
        return a == addr_t'(DEPTH - 1);
    endfunction

    function automatic logic in_user(input addr_t a);
        return a >= addr_t'(USER_BASE);
    endfunction

endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
    import mbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ale,
    input  addr_t ad_addr,
    output addr_t addr
);
    logic ale_q;
    logic ale_fall;

    assign ale_fall = ale_q & ~ale;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            addr  <= '0;
        end else begin
            ale_q <= ale;
            if (ale_fall)
                addr <= ad_addr;
        end
    end

    // R1/R2: outside an ALE fall the latched address does not move
    a_r2_addr_holds: assert property (@(posedge clk) disable iff (rst)
        !(ale_q && !ale) |=> $stable(addr));

endmodule

// File: rtl/mbus_strobe_decode.sv
module mbus_strobe_decode
    import mbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_n,
    input  logic  rd_n,
    input  logic  wr_n,
    input  data_t ad_in,
    input  addr_t addr,
    input  logic  sweep_busy,
    output wr_port_t host_wr,
    output logic  oe
);
    logic  cs_n_q;
    logic  wr_n_q;
    data_t wdata;
    logic  wr_rise;

    assign wr_rise = wr_n & ~wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            wdata  <= '0;
        end else begin
            cs_n_q <= cs_n;
            wr_n_q <= wr_n;
            if (!cs_n && !wr_n)
                wdata <= ad_in;
        end
    end

    always_comb begin
        host_wr.we   = wr_rise & ~cs_n_q & ~sweep_busy;
        host_wr.addr = addr;
        host_wr.data = wdata;
    end

    assign oe = ~cs_n & ~rd_n;

    // R3: a commit implies chip select and write strobe were both low one edge earlier
    a_r3_commit_in_cs: assert property (@(posedge clk) disable iff (rst)
        host_wr.we |-> ($past(cs_n) == 1'b0 && $past(wr_n) == 1'b0));

endmodule

// File: rtl/mbus_clear_seq.sv
module mbus_clear_seq
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_n,
    input  logic     clr_en,
    output wr_port_t clr_wr,
    output logic     busy,
    output logic     done
);
    sweep_state_e state;
    addr_t        ptr;
    logic         clr_n_q;
    logic         start;

    assign start = (state == SWEEP_IDLE) & clr_n_q & ~clr_n & clr_en;
    assign busy  = (state == SWEEP_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SWEEP_IDLE;
            ptr     <= '0;
            clr_n_q <= 1'b1;
            done    <= 1'b0;
        end else begin
            clr_n_q <= clr_n;
            done    <= 1'b0;
            unique case (state)
                SWEEP_IDLE: begin
                    if (start) begin
                        state <= SWEEP_RUN;
                        ptr   <= addr_t'(USER_BASE);
                    end
                end
                SWEEP_RUN: begin
                    if (is_last(ptr)) begin
                        state <= SWEEP_IDLE;
                        done  <= 1'b1;
                    end else begin
                        ptr <= ptr + addr_t'(1);
                    end
                end
                default: state <= SWEEP_IDLE;
            endcase
        end
    end

    always_comb begin
        clr_wr.we   = busy;
        clr_wr.addr = ptr;
        clr_wr.data = '0;
    end

    // R5: consecutive sweep writes step up by one address
    a_r5_sweep_ascends: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (ptr == $past(ptr) + addr_t'(1)));
    // R5: done pulses only right after the sweep ends
    a_r5_done_after_run: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R6: a sweep only begins when the enable bit was set
    a_r6_start_needs_en: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(clr_en));

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_port_t host_wr,
    input  wr_port_t clr_wr,
    input  addr_t    rd_addr,
    output data_t    rd_data,
    output logic     clr_en
);
    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++)
                mem[i] <= '0;
        end else if (clr_wr.we) begin
            mem[clr_wr.addr] <= clr_wr.data;
        end else if (host_wr.we) begin
            mem[host_wr.addr] <= host_wr.data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign clr_en  = mem[CLR_EN_ADDR][CLR_EN_BIT];

    // R7: the sweep never touches the control bytes
    a_r7_sweep_in_user: assert property (@(posedge clk) disable iff (rst)
        clr_wr.we |-> in_user(clr_wr.addr));
    // R8: host and sweep never write in the same cycle
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(clr_wr.we && host_wr.we));

endmodule

// File: rtl/mbus_reg_if.sv
module mbus_reg_if
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic              clr_n,
    output logic              clr_busy,
    output logic              clr_done
);
    addr_t    addr;
    wr_port_t host_wr;
    wr_port_t clr_wr;
    logic     clr_en;

    mbus_addr_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ale     (ale),
        .ad_addr (ad_in[ADDR_W-1:0]),
        .addr    (addr)
    );

    mbus_strobe_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .ad_in      (ad_in),
        .addr       (addr),
        .sweep_busy (clr_busy),
        .host_wr    (host_wr),
        .oe         (ad_oe)
    );

    mbus_clear_seq u_sweep (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .clr_en (clr_en),
        .clr_wr (clr_wr),
        .busy   (clr_busy),
        .done   (clr_done)
    );

    mbus_regfile u_mem (
        .clk     (clk),
        .rst     (rst),
        .host_wr (host_wr),
        .clr_wr  (clr_wr),
        .rd_addr (addr),
        .rd_data (ad_out),
        .clr_en  (clr_en)
    );

    // R4: the bus is never driven while the read strobe is high
    a_r4_oe_needs_rd: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> !ad_oe);

endmodule

// File: tb/tb_mbus_reg_if.sv
module tb_mbus_reg_if;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic       clr_n = 1'b1;
    logic       clr_busy;
    logic       clr_done;

    always #10 clk = ~clk;

    mbus_reg_if dut (
        .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .clr_n(clr_n), .clr_busy(clr_busy), .clr_done(clr_done)
    );

    typedef struct {
        int         req;
        logic [7:0] exp;
        logic [6:0] addr;
    } rd_item_t;

    rd_item_t   sb_q[$];
    logic [7:0] model [128];
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         finished = 0;

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected byte per read strobe cycle
    always @(negedge clk) begin
        if (!cs_n && !rd_n && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check(it.req, $sformatf("oe on read of %0h", it.addr), 32'(ad_oe), 32'd1);
            check(it.req, $sformatf("data at %0h", it.addr), 32'(ad_out), 32'(it.exp));
        end
    end

    task automatic drive_step();
        @(posedge clk);
        #2;
    endtask

    task automatic addr_phase(input logic [7:0] a);
        drive_step(); ale = 1'b1; ad_in = a;
        drive_step(); ale = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit sel, input bit early_drop);
        addr_phase(a);
        drive_step(); ad_in = d; cs_n = !sel; wr_n = 1'b0;
        if (early_drop) begin
            drive_step(); cs_n = 1'b1;
        end
        drive_step(); wr_n = 1'b1;
        drive_step(); cs_n = 1'b1;
    endtask

    task automatic read_here(input int req, input logic [6:0] a);
        rd_item_t it;
        drive_step(); cs_n = 1'b0; rd_n = 1'b0;
        it.req = req; it.exp = model[a]; it.addr = a;
        sb_q.push_back(it);
        drive_step(); rd_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_read(input int req, input logic [7:0] a);
        addr_phase(a);
        read_here(req, a[6:0]);
    endtask

    task automatic mwrite(input logic [6:0] a, input logic [7:0] d);
        bus_write({1'b0, a}, d, 1'b1, 1'b0);
        model[a] = d;
    endtask

    task automatic run_clear(input int req, output int busy_cnt, output int done_cnt);
        busy_cnt = 0; done_cnt = 0;
        drive_step(); clr_n = 1'b0;
        drive_step(); clr_n = 1'b1;  // early release, R8
        for (int k = 0; k < 140; k++) begin
            @(negedge clk);
            if (clr_busy) busy_cnt++;
            if (clr_done) done_cnt++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int bc, dc;
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(9, "oe after reset", 32'(ad_oe), 0);
        check(9, "busy after reset", 32'(clr_busy), 0);
        check(9, "done after reset", 32'(clr_done), 0);
        bus_read(9, 8'h10);
        bus_read(9, 8'h00);

        // R1/R3 writes and readback over user RAM and control bytes
        mwrite(7'h0E, 8'hA1);
        mwrite(7'h7F, 8'hB2);
        mwrite(7'h40, 8'hC3);
        mwrite(7'h03, 8'h5A);
        mwrite(7'h0D, 8'hD4);
        bus_read(3, 8'h0E);
        bus_read(3, 8'h7F);
        bus_read(1, 8'h40);
        bus_read(1, 8'h03);
        bus_read(1, 8'h0D);
        // R1: bit 7 of the address phase is ignored
        bus_write(8'h90, 8'h66, 1'b1, 1'b0); model[7'h10] = 8'h66;
        bus_read(1, 8'h10);

        // R2: ALE with chip select high moves the address, no data moves
        mwrite(7'h30, 8'h11);
        bus_write(8'h31, 8'h55, 1'b0, 1'b0);
        read_here(2, 7'h31);
        bus_read(2, 8'h31);
        bus_read(2, 8'h30);

        // R3: chip select released before the write strobe: nothing written
        bus_write(8'h50, 8'h99, 1'b1, 1'b1);
        bus_read(3, 8'h50);

        // R4: output enable needs both strobes
        drive_step(); cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk); check(4, "oe with cs high", 32'(ad_oe), 0);
        drive_step(); cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); check(4, "oe with rd high", 32'(ad_oe), 0);
        drive_step(); cs_n = 1'b1;

        // R6: enable off, wipe request ignored
        mwrite(7'h0A, 8'h00);
        run_clear(6, bc, dc);
        check(6, "busy cycles with enable off", 32'(bc), 0);
        check(6, "done pulses with enable off", 32'(dc), 0);
        bus_read(6, 8'h40);
        bus_read(6, 8'h7F);

        // R5: enabled sweep, R8 early release
        mwrite(7'h0A, 8'h01);
        run_clear(5, bc, dc);
        check(5, "busy cycle count", 32'(bc), 114);
        check(5, "done pulse count", 32'(dc), 1);
        for (int i = 14; i < 128; i++) model[i] = 8'h00;
        // R7 control bytes kept, R5 user bytes zero
        for (int i = 0; i < 128; i++)
            bus_read((i < 14) ? 7 : 5, 8'(i));

        // R8: host writes during a sweep are dropped
        mwrite(7'h20, 8'h77);
        mwrite(7'h05, 8'h3C);
        drive_step(); clr_n = 1'b0;
        drive_step(); clr_n = 1'b1;
        bus_write(8'h05, 8'hEE, 1'b1, 1'b0);
        bus_write(8'h21, 8'h12, 1'b1, 1'b0);
        @(negedge clk);
        check(8, "still busy after host writes", 32'(clr_busy), 1);
        for (int k = 0; k < 200 && clr_busy; k++) @(negedge clk);
        model[7'h20] = 8'h00;
        bus_read(8, 8'h05);
        bus_read(8, 8'h21);
        bus_read(8, 8'h20);
        bus_read(7, 8'h0A);
        // after the sweep writes work again
        mwrite(7'h22, 8'h44);
        bus_read(8, 8'h22);

        repeat (3) @(posedge clk);
        check(4, "scoreboard drained", 32'(sb_q.size()), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule